// File: doc/BRIEF.md
# Periodic Schedule Base-Time Adjuster

This block moves a requested schedule start time into the near future while keeping its phase. A time-aware scheduler needs a start time that the hardware has not yet passed. Software may supply a stale one. The block takes three inputs: the requested time, the cycle period and a snapshot of the free-running nanosecond clock. It returns a start time that differs from the request by a whole number of periods and falls inside a one-period window that opens two periods after the current time.

The block needs no 64-bit divider. It first doubles the period until the doubled value covers the distance to the threshold. It then walks back down through the power-of-two multiples, adding at most one multiple per clock cycle, and finishes with one more period. A single-cycle `start` launches a request. `done` pulses once when the result is ready. Requests made while the block is busy are dropped.

Top module: `base_time_adjust`

## Requirements
- R1: After a synchronous active-low reset, `done`, `busy` and `err` are 0 and `adj_time` is 0.
- R2: The threshold is `now_time + 2*period`. When `req_time` is greater than or equal to the threshold (equality included), `adj_time` equals `req_time` and `err` is 0.
- R3: When `req_time` is below the threshold, `adj_time` equals `req_time + N*period`, where N is the smallest integer that makes the result at least the threshold.
- R4: For any non-zero period with `req_time` below the threshold, the result satisfies threshold <= `adj_time` < threshold + `period`.
- R5: A zero `period` completes with `err` = 1 and `adj_time` = `req_time`. In all other cases `err` is 0 during `done`.
- R6: `done` is a single-cycle pulse. `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1, where it is 0.
- R7: A `start` seen while `busy` is 1 is ignored. It produces no extra `done`, and the result of the running request is unaffected.
- R8: `done` arrives no more than 3*(TIME_W+2)+4 cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled only when idle |
| req_time | input | TIME_W (64) | Requested start time, ns |
| now_time | input | TIME_W (64) | Current clock snapshot, ns |
| period | input | PER_W (32) | Schedule cycle period, ns |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Zero period flagged, valid with `done` |
| adj_time | output | TIME_W (64) | Adjusted start time, valid with `done` |

## Verification
The bench aims at these corner cases:
- A request exactly at the threshold must pass through. A design comparing with `>` instead would push it one period later.
- A request one nanosecond below the threshold must move forward by exactly one period.
- A unit period with a large gap drives the chunk search through about forty levels. An off-by-one in the scale or descend steps shows up as a result one period early or late.
- A zero period must raise `err` and must not hang the search.
- Starts pulsed while busy would produce a spurious `done` if the design accepted them. The scoreboard finds such a `done` with no matching entry in its queue.

// File: rtl/bta_pkg.sv
// Shared types for the base-time adjuster.
package bta_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCALE,
        ST_DESCEND
    } bta_state_e;
endpackage

// File: rtl/bta_threshold.sv
// Computes the earliest allowed start: now + 2*period.
// Assumes the sum fits in TIME_W+1 bits (always true for these widths).
module bta_threshold #(
    parameter int TIME_W = 64,
    parameter int PER_W  = 32
) (
    input  logic [TIME_W-1:0] now_time,
    input  logic [PER_W-1:0]  period,
    output logic [TIME_W:0]   thr
);
    // Doubling the period is a one-bit shift folded into the adder operand.
    assign thr = {1'b0, now_time} + {{(TIME_W-PER_W){1'b0}}, period, 1'b0};
endmodule

// File: rtl/bta_chunk_step.sv
// One trial step of the chunk walk: candidate = acc + chunk, and whether it
// is still below the threshold. Purely combinational.
module bta_chunk_step #(
    parameter int TIME_W = 64,
    localparam int W     = TIME_W + 3
) (
    input  logic [TIME_W-1:0] acc,
    input  logic [W-1:0]      chunk,
    input  logic [TIME_W:0]   thr,
    output logic [W-1:0]      sum,
    output logic              below
);
    // Single add followed by a single compare.
    assign sum   = {3'b000, acc} + chunk;
    assign below = sum < {2'b00, thr};
endmodule

// File: rtl/base_time_adjust.sv
// Adjusts a requested schedule start time to lie in
// [now + 2*period, now + 3*period) while keeping it congruent to the request
// modulo period. Requests already at or past the threshold pass through.
// Uses a power-of-two chunk search: scale up until chunk >= gap, then descend,
// at most one add per level. Assumes now + 3*period does not wrap TIME_W.
module base_time_adjust #(
    parameter int TIME_W = 64,
    parameter int PER_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TIME_W-1:0] req_time,
    input  logic [TIME_W-1:0] now_time,
    input  logic [PER_W-1:0]  period,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [TIME_W-1:0] adj_time
);
    import bta_pkg::*;

    localparam int W    = TIME_W + 3;
    localparam int LVLW = $clog2(TIME_W + 3);

    bta_state_e        state;
    logic [TIME_W-1:0] base_q;
    logic [PER_W-1:0]  per_q;
    logic [TIME_W:0]   thr_q;
    logic [TIME_W:0]   thr_in;
    logic [TIME_W:0]   gap;
    logic [TIME_W-1:0] acc_q;
    logic [W-1:0]      chunk_q;
    logic [LVLW-1:0]   lvl_q;
    logic [W-1:0]      step_sum;
    logic              step_below;

    bta_threshold #(.TIME_W(TIME_W), .PER_W(PER_W)) u_thr (
        .now_time (now_time),
        .period   (period),
        .thr      (thr_in)
    );

    bta_chunk_step #(.TIME_W(TIME_W)) u_step (
        .acc   (acc_q),
        .chunk (chunk_q),
        .thr   (thr_q),
        .sum   (step_sum),
        .below (step_below)
    );

    // Distance still to cover; only meaningful while base is below threshold.
    assign gap  = thr_q - {1'b0, base_q};
    assign busy = (state != ST_IDLE);

    // Control sequence: capture, check, scale the chunk up, walk it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base_q   <= '0;
            per_q    <= '0;
            thr_q    <= '0;
            acc_q    <= '0;
            chunk_q  <= '0;
            lvl_q    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            adj_time <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= req_time;
                        per_q  <= period;
                        thr_q  <= thr_in;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (per_q == '0) begin
                        adj_time <= base_q;
                        err      <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else if ({1'b0, base_q} >= thr_q) begin
                        adj_time <= base_q;
                        err      <= 1'b0;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        acc_q   <= base_q;
                        chunk_q <= {{(W-PER_W){1'b0}}, per_q};
                        lvl_q   <= '0;
                        state   <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (chunk_q < {2'b00, gap}) begin
                        chunk_q <= chunk_q << 1;
                        lvl_q   <= lvl_q + 1'b1;
                    end else begin
                        state <= ST_DESCEND;
                    end
                end
                ST_DESCEND: begin
                    if (step_below) begin
                        acc_q <= step_sum[TIME_W-1:0];
                    end else if (lvl_q == '0) begin
                        // chunk is one period here, so the sum is the answer
                        adj_time <= step_sum[TIME_W-1:0];
                        err      <= 1'b0;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        chunk_q <= chunk_q >> 1;
                        lvl_q   <= lvl_q - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && ({1'b0, base_q} >= thr_q)) |-> (adj_time == base_q));

    assert_window_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && ({1'b0, base_q} < thr_q)) |-> ({1'b0, adj_time} >= thr_q));

    assert_window_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && ({1'b0, base_q} < thr_q))
        |-> ({2'b00, adj_time} < ({1'b0, thr_q} + {{(TIME_W+2-PER_W){1'b0}}, per_q})));

    assert_zero_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ((per_q == '0) && (adj_time == base_q)));

    assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(per_q) && $stable(thr_q)));

    assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lvl_q <= LVLW'(TIME_W + 2)));
endmodule

// File: tb/tb_base_time_adjust.sv
module tb_base_time_adjust;
    localparam int TIME_W  = 64;
    localparam int PER_W   = 32;
    localparam int LAT_MAX = 3 * (TIME_W + 2) + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TIME_W-1:0] req_time = '0;
    logic [TIME_W-1:0] now_time = '0;
    logic [PER_W-1:0]  period = '0;
    logic              busy, done, err;
    logic [TIME_W-1:0] adj_time;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [TIME_W-1:0] exp_time;
        logic              exp_err;
        logic [TIME_W-1:0] thr;
        logic [TIME_W-1:0] per;
        logic              moved;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    base_time_adjust #(.TIME_W(TIME_W), .PER_W(PER_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_time(req_time),
        .now_time(now_time), .period(period), .busy(busy), .done(done),
        .err(err), .adj_time(adj_time)
    );

    task automatic check(input bit ok, input string req, input logic [TIME_W-1:0] act,
                         input logic [TIME_W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: compute the expected item independently, push it, issue start.
    task automatic issue(input logic [TIME_W-1:0] b, input logic [TIME_W-1:0] n,
                         input logic [PER_W-1:0] c, input bit poke_busy);
        exp_t e;
        logic [TIME_W-1:0] th;
        logic [TIME_W-1:0] k;
        int lat;
        th = n + 2 * TIME_W'(c);
        e.thr = th; e.per = TIME_W'(c); e.moved = 1'b0;
        if (c == 0) begin
            e.exp_time = b; e.exp_err = 1'b1;
        end else if (b >= th) begin
            e.exp_time = b; e.exp_err = 1'b0;
        end else begin
            k = (th - b + TIME_W'(c) - 1) / TIME_W'(c);
            e.exp_time = b + k * TIME_W'(c); e.exp_err = 1'b0; e.moved = 1'b1;
        end
        while (busy) @(negedge clk);
        sb.push_back(e);
        req_time = b; now_time = n; period = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        // R6: busy must be up in the cycle after an accepted start
        check(busy === 1'b1 || done === 1'b1, "R6 busy after start", TIME_W'(busy), 1);
        while (!done && lat < 2 * LAT_MAX) begin
            if (poke_busy && lat < 3) begin
                // R7: extra requests while busy must be dropped
                req_time = 64'd7; now_time = 64'd1000; period = 32'd3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat <= LAT_MAX, "R8 latency", TIME_W'(lat), TIME_W'(LAT_MAX));
        @(negedge clk);
        check(done === 1'b0, "R6 done single pulse", TIME_W'(done), 0);
    endtask

    // Monitor: pop expected item on every done and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected done", adj_time, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(adj_time === e.exp_time,
                      e.exp_err ? "R5 zero period value" : (e.moved ? "R3 aligned result" : "R2 passthrough"),
                      adj_time, e.exp_time);
                check(err === e.exp_err, "R5 err flag", TIME_W'(err), TIME_W'(e.exp_err));
                check(busy === 1'b0, "R6 busy low at done", TIME_W'(busy), 0);
                if (e.moved) begin
                    check(adj_time >= e.thr, "R4 window low", adj_time, e.thr);
                    check(adj_time < e.thr + e.per, "R4 window high", adj_time, e.thr + e.per);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done === 1'b0, "R1 done", TIME_W'(done), 0);
        check(busy === 1'b0, "R1 busy", TIME_W'(busy), 0);
        check(err === 1'b0, "R1 err", TIME_W'(err), 0);
        check(adj_time === '0, "R1 adj_time", adj_time, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(64'd0, 64'd1_000_000, 32'd1000, 1'b0);          // R3 stale request
        issue(64'd1_002_000, 64'd1_000_000, 32'd1000, 1'b0);  // R2 exactly at threshold
        issue(64'd1_002_001, 64'd1_000_000, 32'd1000, 1'b0);  // R2 beyond threshold
        issue(64'd1_001_999, 64'd1_000_000, 32'd1000, 1'b0);  // R3 one below threshold
        issue(64'd5, 64'h0000_0123_4567_89AB, 32'd1, 1'b0);   // R3 unit period, deep search
        issue(64'd123, 64'd456, 32'd0, 1'b0);                 // R5 zero period
        issue(64'd5, 64'h0000_1234_5678_9ABC, 32'hFFFF_FFFF, 1'b0); // R4 wide period
        issue(64'd17, 64'd50_000, 32'd333, 1'b1);             // R7 starts while busy
        issue(64'd0, 64'h3FFF_FFFF_FFFF_0000, 32'd1, 1'b0);   // R8 near worst-case depth
        for (int i = 0; i < 12; i++) begin
            logic [TIME_W-1:0] nw, bs;
            logic [PER_W-1:0]  cy;
            nw = {2'b00, 30'($urandom), $urandom};
            bs = (i % 3 == 0) ? nw + TIME_W'($urandom) : nw - {32'd0, $urandom} * 64'd7;
            cy = (i % 2 == 0) ? $urandom : ($urandom % 32'd5000) + 32'd1;
            issue(bs, nw, cy, i % 4 == 1);
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 leftover expected items", TIME_W'(sb.size()), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 150_000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule